// File: doc/BRIEF.md
# Security-Aware Exception Priority Resolver

This block decides whether a pending exception may interrupt the code that is running now. It keeps a priority level for each exception in each of two security states (secure and non-secure), so every exception has two independently programmed instances. Each stored level is turned into an 8-bit effective priority. When a secure-only boost control is set, every non-secure priority is squeezed into the lower-urgency half of the range. Numerically larger values mean less urgent.

On every cycle the block chooses the most urgent pending instance. It compares that winner against the running priority supplied by the surrounding core and registers a preempt request together with the winner's exception number and security state. Software programs the levels and the boost control through a write port that carries the security attribute of each access. The control register is guarded by a key.

Top module: `sec_prio_resolver`

## Requirements
- R1: A write to address i (0 to NUM_EXC-1) stores wr_data[7:6] as the level n of exception i, and its raw priority becomes n shifted left by 6. Bits [5:0] of the data have no effect.
- R2: When the boost bit is 1, each non-secure effective priority equals {1'b1, raw[7:1]}. Secure effective priorities always equal their raw value, and with boost at 0 non-secure ones do too.
- R3: A preempt request is raised only when the winner's effective priority is strictly below run_prio. An equal value never preempts, including a secure 0x80 against a running 0x80.
- R4: Each exception has one register per security state. A priority write changes only the register of the bank named by wr_secure (1 = secure).
- R5: A write to the control address NUM_EXC updates the boost bit from wr_data[14] only when wr_data[31:16] equals 16'h05FA. Any other key leaves the bit unchanged.
- R6: A non-secure access never changes the boost bit.
- R7: After reset all levels are 0 and the boost bit is 0.
- R8: Among pending instances the lowest effective priority wins. A tie goes to the lower exception number, and a tie on the number goes to the secure instance.
- R9: preempt, win_num and win_sec are registered. They reflect the inputs and register state that were present at the previous rising clock edge.
- R10: With nothing pending, preempt is 0, win_num is NUM_EXC (the idle code) and win_sec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Write address: exception index, or NUM_EXC for control |
| wr_data | input | 32 | Write data |
| wr_secure | input | 1 | Security attribute of the write (1 = secure) |
| pend_s | input | NUM_EXC | Pending flags, secure instances |
| pend_ns | input | NUM_EXC | Pending flags, non-secure instances |
| run_prio | input | 8 | Current running priority |
| preempt | output | 1 | Preemption request |
| win_num | output | ADDR_W (3) | Winning exception number, NUM_EXC when idle |
| win_sec | output | 1 | Winner is the secure instance |

## Verification
A corrupted level register, a bank mix-up or a wrongly set boost bit changes which instance wins, or whether preemption is requested. The error shows on win_num, win_sec or preempt one clock after the pending pattern that exposes it. The bench sweeps every pending mask against several running priorities for many register configurations. A wrong stored value therefore appears within the first mask that pits the affected instance against another instance. Rejected key writes and non-secure control writes are followed by a mask whose outcome depends on the boost bit.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int unsigned PRIO_W    = 8;
    localparam logic [15:0] CTRL_KEY  = 16'h05FA;
    localparam int unsigned BOOST_BIT = 14;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/spr_regs.sv
module spr_regs
    import spr_pkg::*;
#(
    parameter int NUM_EXC  = 4,
    parameter int LVL_BITS = 2,
    parameter int ADDR_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic                     wr_secure,
    output logic [NUM_EXC-1:0][7:0]  raw_s,
    output logic [NUM_EXC-1:0][7:0]  raw_ns,
    output logic                     boost
);
    localparam int PAD_W = PRIO_W - LVL_BITS;

    typedef struct packed {
        logic [NUM_EXC-1:0][LVL_BITS-1:0] lvl_s;
        logic [NUM_EXC-1:0][LVL_BITS-1:0] lvl_ns;
        logic                             boost;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_data;

    assign unused_data = ^{wr_data[15], wr_data[13:PRIO_W], wr_data[PAD_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_EXC; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    if (wr_secure) st_d.lvl_s[i]  = wr_data[PRIO_W-1 -: LVL_BITS];
                    else           st_d.lvl_ns[i] = wr_data[PRIO_W-1 -: LVL_BITS];
                end
            end
            if (wr_addr == ADDR_W'(NUM_EXC) && wr_secure && wr_data[31:16] == CTRL_KEY)
                st_d.boost = wr_data[BOOST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boost = st_q.boost;

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_raw
        assign raw_s[g]  = {st_q.lvl_s[g],  {PAD_W{1'b0}}};
        assign raw_ns[g] = {st_q.lvl_ns[g], {PAD_W{1'b0}}};

        AST_BANK_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_secure) |=> $stable(st_q.lvl_ns[g]))
            else $error("secure write altered non-secure bank"); // R4
    end

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(NUM_EXC) && wr_data[31:16] != CTRL_KEY) |=> $stable(st_q.boost))
        else $error("bad key changed boost"); // R5

    AST_NS_CTRL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_secure) |=> $stable(st_q.boost))
        else $error("non-secure write changed boost"); // R6
endmodule

// File: rtl/spr_remap.sv
module spr_remap #(
    parameter int NUM_EXC = 4
) (
    input  logic [NUM_EXC-1:0][7:0] raw_ns,
    input  logic                    boost,
    output logic [NUM_EXC-1:0][7:0] eff_ns
);
    for (genvar g = 0; g < NUM_EXC; g++) begin : g_map
        assign eff_ns[g] = boost ? {1'b1, raw_ns[g][7:1]} : raw_ns[g];
    end

    always_comb begin
        for (int i = 0; i < NUM_EXC; i++) begin
            for (int j = 0; j < NUM_EXC; j++) begin
                if (raw_ns[i] < raw_ns[j]) begin
                    AST_ORDER_KEPT: assert (eff_ns[i] <= eff_ns[j])
                        else $error("remap broke priority order"); // R2
                end
            end
        end
    end
endmodule

// File: rtl/spr_arbiter.sv
module spr_arbiter #(
    parameter int NUM_EXC = 4,
    parameter int NUM_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EXC-1:0]      pend_s,
    input  logic [NUM_EXC-1:0]      pend_ns,
    input  logic [NUM_EXC-1:0][7:0] eff_s,
    input  logic [NUM_EXC-1:0][7:0] eff_ns,
    input  logic [7:0]              run_prio,
    output logic                    preempt,
    output logic [NUM_W-1:0]        win_num,
    output logic                    win_sec
);
    localparam logic [NUM_W-1:0] IDLE = NUM_W'(NUM_EXC);

    typedef struct packed {
        logic             preempt;
        logic [NUM_W-1:0] num;
        logic             sec;
    } arb_t;

    arb_t       arb_d, arb_q;
    logic [8:0] best;

    always_comb begin
        best      = 9'h100;
        arb_d.num = IDLE;
        arb_d.sec = 1'b0;
        for (int n = 0; n < NUM_EXC; n++) begin
            if (pend_s[n] && {1'b0, eff_s[n]} < best) begin
                best      = {1'b0, eff_s[n]};
                arb_d.num = NUM_W'(n);
                arb_d.sec = 1'b1;
            end
            if (pend_ns[n] && {1'b0, eff_ns[n]} < best) begin
                best      = {1'b0, eff_ns[n]};
                arb_d.num = NUM_W'(n);
                arb_d.sec = 1'b0;
            end
        end
        arb_d.preempt = (best < {1'b0, run_prio});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '{preempt: 1'b0, num: IDLE, sec: 1'b0};
        else        arb_q <= arb_d;
    end

    assign preempt = arb_q.preempt;
    assign win_num = arb_q.num;
    assign win_sec = arb_q.sec;

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_s == '0 && pend_ns == '0) |=> (!preempt && win_num == IDLE && !win_sec))
        else $error("idle outputs wrong"); // R10

    AST_ZERO_RUN_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == 8'h00) |=> !preempt)
        else $error("preempt against running priority 0"); // R3

    AST_PREEMPT_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> (win_num != IDLE))
        else $error("preempt without winner"); // R9
endmodule

// File: rtl/sec_prio_resolver.sv
module sec_prio_resolver #(
    parameter  int NUM_EXC  = 4,
    parameter  int LVL_BITS = 2,
    localparam int ADDR_W   = $clog2(NUM_EXC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               wr_secure,
    input  logic [NUM_EXC-1:0] pend_s,
    input  logic [NUM_EXC-1:0] pend_ns,
    input  logic [7:0]         run_prio,
    output logic               preempt,
    output logic [ADDR_W-1:0]  win_num,
    output logic               win_sec
);
    logic [NUM_EXC-1:0][7:0] raw_s, raw_ns, eff_ns;
    logic                    boost;

    spr_regs #(.NUM_EXC(NUM_EXC), .LVL_BITS(LVL_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_secure(wr_secure),
        .raw_s(raw_s), .raw_ns(raw_ns), .boost(boost)
    );

    spr_remap #(.NUM_EXC(NUM_EXC)) u_remap (
        .raw_ns(raw_ns), .boost(boost), .eff_ns(eff_ns)
    );

    spr_arbiter #(.NUM_EXC(NUM_EXC), .NUM_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend_s(pend_s), .pend_ns(pend_ns),
        .eff_s(raw_s), .eff_ns(eff_ns), .run_prio(run_prio),
        .preempt(preempt), .win_num(win_num), .win_sec(win_sec)
    );
endmodule

// File: tb/sec_prio_resolver_tb.sv
`timescale 1ns/1ps
module sec_prio_resolver_tb;
    localparam int N = 4;
    localparam logic [2:0] CTRL = 3'd4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_secure = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [N-1:0] pend_s = '0, pend_ns = '0;
    logic [7:0] run_prio = '0;
    logic       preempt, win_sec;
    logic [2:0] win_num;

    int checks = 0, fails = 0;
    int m_lvl_s [N];
    int m_lvl_ns[N];
    bit m_boost;

    always #2.5 clk = ~clk;

    sec_prio_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_secure(wr_secure), .pend_s(pend_s),
        .pend_ns(pend_ns), .run_prio(run_prio), .preempt(preempt),
        .win_num(win_num), .win_sec(win_sec)
    );

    task automatic do_write(input logic [2:0] a, input logic [31:0] d, input bit sec);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_secure = sec;
        if (a < 3'(N)) begin
            if (sec) m_lvl_s[a] = int'(d[7:6]);
            else     m_lvl_ns[a] = int'(d[7:6]);
        end else if (a == CTRL && sec && d[31:16] == 16'h05FA) begin
            m_boost = d[14];
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input logic [N-1:0] ps, input logic [N-1:0] pn,
                              output bit e_pre, output int e_num, output bit e_sec);
        int best = 256;
        e_num = N; e_sec = 0;
        for (int n = 0; n < N; n++) begin
            int es = m_lvl_s[n] * 64;
            int en = m_boost ? (128 + m_lvl_ns[n] * 32) : m_lvl_ns[n] * 64;
            if (ps[n] && es < best) begin best = es; e_num = n; e_sec = 1; end
            if (pn[n] && en < best) begin best = en; e_num = n; e_sec = 0; end
        end
        e_pre = (best < int'(run_prio));
    endtask

    task automatic compare(input string tag);
        bit e_pre, e_sec; int e_num;
        expect_out(pend_s, pend_ns, e_pre, e_num, e_sec);
        checks++;
        if (preempt !== e_pre || win_num !== 3'(e_num) || win_sec !== e_sec) begin
            fails++;
            $display("FAIL %s: ps=%b pn=%b run=%h got pre=%b num=%0d sec=%b exp pre=%b num=%0d sec=%b",
                     tag, pend_s, pend_ns, run_prio, preempt, win_num, win_sec, e_pre, e_num, e_sec);
        end
    endtask

    task automatic chk(input logic [N-1:0] ps, input logic [N-1:0] pn,
                       input logic [7:0] rp, input string tag);
        @(negedge clk);
        pend_s = ps; pend_ns = pn; run_prio = rp;
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] runs [4];
        runs[0] = 8'h00; runs[1] = 8'h40; runs[2] = 8'h80; runs[3] = 8'hC0;
        for (int i = 0; i < N; i++) begin m_lvl_s[i] = 0; m_lvl_ns[i] = 0; end
        m_boost = 0;
        #12; rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R10 reset idle");
        chk('1, '1, 8'hFF, "R7 reset levels zero, R8 secure wins tie");
        chk('0, 4'b0001, 8'h40, "R7 boost clear after reset");
        chk('0, '0, 8'hFF, "R10 idle code");

        // document scenario: secure level 2 vs running remapped 0x80
        do_write(3'd1, 32'h0000_0080, 1'b1);
        do_write(CTRL, 32'h05FA_4000, 1'b1);
        chk(4'b0010, '0, 8'h80, "R3 equal priority no preempt");
        chk('0, 4'b0001, 8'h81, "R2 non-secure remapped to 0x80");
        // R6: non-secure clear attempt with good key
        do_write(CTRL, 32'h05FA_0000, 1'b0);
        chk('0, 4'b0001, 8'h80, "R6 non-secure cannot clear boost");
        // R5: wrong key
        do_write(CTRL, 32'h05FB_0000, 1'b1);
        chk('0, 4'b0001, 8'h80, "R5 wrong key ignored");
        do_write(CTRL, 32'h05FA_0000, 1'b1);
        chk('0, 4'b0001, 8'h80, "R5 correct key clears boost");
        // R4 banking: non-secure write must not touch secure level of exc 1
        do_write(3'd1, 32'h0000_00C0, 1'b0);
        chk(4'b0010, '0, 8'hFF, "R4 secure bank kept");
        chk('0, 4'b0010, 8'hC1, "R4 non-secure bank written");
        // R1 low bits ignored
        do_write(3'd2, 32'h0000_007F, 1'b1);
        chk(4'b0100, '0, 8'h41, "R1 low data bits ignored");
        // R9 latency
        chk(4'b0100, '0, 8'hFF, "R9 setup");
        @(negedge clk); pend_s = '0; #1;
        checks++;
        if (preempt !== 1'b1) begin
            fails++; $display("FAIL R9: got pre=%b exp pre=1 before edge", preempt);
        end
        @(posedge clk); #1;
        compare("R9 update after one edge");

        // sweep configurations
        for (int cfg = 0; cfg < 6; cfg++) begin
            for (int n = 0; n < N; n++) begin
                do_write(3'(n), {24'h0, 2'((cfg + n * 3) % 4), 6'(cfg * 7 + n)}, 1'b1);
                do_write(3'(n), {24'h0, 2'((cfg * 2 + n + 1) % 4), 6'(n * 5)}, 1'b0);
            end
            do_write(CTRL, {16'h05FA, 1'b0, 1'(cfg), 14'h0}, 1'b1);
            do_write(CTRL, {16'h05FA, 1'b0, 1'(~cfg[0]), 14'h0}, 1'b0);
            do_write(CTRL, {16'h1234, 1'b0, 1'(~cfg[0]), 14'h0}, 1'b1);
            for (int p = 0; p < 256; p++) begin
                for (int r = 0; r < 4; r++) begin
                    chk(4'(p), 4'(p >> 4), runs[r], "R2/R3/R8 sweep");
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule